// File: doc/BRIEF.md
# Strobed Switch-Bank Programming Sequencer

This block sits on the host side of a group of quad analog switch devices. Each device has four control inputs and a latch strobe, and it copies the control inputs into its switch register on the rising edge of that strobe, at no other time. The sequencer takes one request at a time over a ready/valid handshake. Each request either names a single device and a four-bit pattern, or asks for a broadcast of a wide vector holding four bits for every device. The sequencer then runs the strobe timing itself, counted in system clock cycles.

In unicast operation a single four-bit bus is shared by every device, and only the addressed device's strobe is pulsed. In broadcast operation each device reads its own four-bit slice of a wide bus, and all strobes rise and fall together. The sequencer changes bus data only while every strobe is low. It holds that data through the setup, the high pulse and a hold interval after the falling edge, and only then takes a new request. A shadow copy of what each device has captured is kept and can be read back. Because the devices start with every switch open, the shadow starts at zero.

Top module: `swbank_seq`

## Requirements
- R1: While reset is high and in the cycle after it, every strobe is low, `req_ready` is high and `err_o` is low. After reset the readback returns 0000 for every device.
- R2: A unicast request with index d below `NUM_DEV` puts its pattern on `ctl_bus` and raises only strobe bit d. Bit i of the pattern controls switch i and 1 means closed.
- R3: The first strobe rises exactly `SETUP_CYC` cycles after the cycle in which the new data first appears on the bus (a value of 0 counts as 1).
- R4: The strobe stays high for exactly `PULSE_CYC` cycles (0 counts as 1).
- R5: After the strobe falls, the bus keeps its value and `req_ready` stays low for exactly `HOLD_CYC` cycles. Then `req_ready` returns high.
- R6: `ctl_bus` and `bcast_bus` change only in a cycle where every strobe is low and was low in the previous cycle.
- R7: A broadcast request drives `bcast_bus` with the wide vector and pulses all strobe bits together. Device d takes bits [4d+3:4d].
- R8: A unicast index at or above `NUM_DEV` raises `err_o` for one cycle, in the cycle after acceptance. It produces no strobe, keeps `req_ready` high and leaves every shadow entry unchanged.
- R9: A shadow entry takes its new value at the clock edge that raises the strobe. `rb_state` returns the entry chosen by `rb_dev` one cycle after `rb_dev` is applied, and returns 0000 for an index at or above `NUM_DEV`.
- R10: While a sequence is in progress `req_ready` is low, and a request presented during that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_bcast | input | 1 | 1 = broadcast the wide vector to all devices |
| req_dev | input | IDX_W | Target device for a unicast request |
| req_pat | input | CH | Switch pattern for a unicast request |
| req_wide | input | NUM_DEV*CH | Per-device patterns for a broadcast |
| err_o | output | 1 | One-cycle flag for a rejected index |
| ctl_bus | output | CH | Shared control bus |
| bcast_bus | output | NUM_DEV*CH | Dedicated per-device control lines |
| latch_o | output | NUM_DEV | Per-device latch strobes |
| rb_dev | input | IDX_W | Readback device index |
| rb_state | output | CH | Shadow state of the selected device |

## Verification
The assertions assume that the request fields stay steady in any cycle where `req_valid` is high. They also assume that reset is held for at least one clock before the first request. The bench changes every input only on the falling clock edge and holds a request for exactly one accepted cycle. It deliberately keeps `req_valid` high during busy periods to show that nothing is taken then. It also mixes in-range, out-of-range and broadcast requests, so that bus changes always occur next to idle strobes.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD} phase_t;

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction
endpackage

// File: rtl/swb_timer.sv
module swb_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] term,
  output logic          hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == term);
endmodule

// File: rtl/swb_shadow.sv
module swb_shadow #(
  parameter int NUM_DEV = 3,
  parameter int CH      = 4,
  parameter int IDX_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_DEV-1:0]    we,
  input  logic [NUM_DEV*CH-1:0] wd,
  input  logic [IDX_W-1:0]      rb_dev,
  output logic [CH-1:0]         rb_state
);
  localparam logic [IDX_W:0] NDEV_L = (IDX_W+1)'(NUM_DEV);

  logic [CH-1:0] mem [NUM_DEV];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < NUM_DEV; d++) mem[d] <= '0;
    end else begin
      for (int d = 0; d < NUM_DEV; d++)
        if (we[d]) mem[d] <= wd[d*CH +: CH];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         rb_state <= '0;
    else if ({1'b0, rb_dev} < NDEV_L) rb_state <= mem[rb_dev];
    else                             rb_state <= '0;
  end
endmodule

// File: rtl/swb_fsm.sv
module swb_fsm
  import swb_pkg::*;
#(
  parameter int NUM_DEV   = 3,
  parameter int CH        = 4,
  parameter int IDX_W     = 2,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_bcast,
  input  logic [IDX_W-1:0]      req_dev,
  input  logic [CH-1:0]         req_pat,
  input  logic [NUM_DEV*CH-1:0] req_wide,
  output logic                  req_ready,
  output logic                  err_o,
  output logic [CH-1:0]         ctl_bus,
  output logic [NUM_DEV*CH-1:0] bcast_bus,
  output logic [NUM_DEV-1:0]    latch_o,
  output logic [NUM_DEV-1:0]    sh_we,
  output logic [NUM_DEV*CH-1:0] sh_wd
);
  localparam int S_EFF = at_least_one(SETUP_CYC);
  localparam int P_EFF = at_least_one(PULSE_CYC);
  localparam int H_EFF = at_least_one(HOLD_CYC);
  localparam int MAXC  = (S_EFF > P_EFF) ? ((S_EFF > H_EFF) ? S_EFF : H_EFF)
                                         : ((P_EFF > H_EFF) ? P_EFF : H_EFF);
  localparam int CW    = $clog2(MAXC + 1) + 1;
  localparam logic [IDX_W:0] NDEV_L = (IDX_W+1)'(NUM_DEV);

  phase_t              phase;
  logic                bc_q;
  logic [IDX_W-1:0]    dev_q;
  logic [NUM_DEV-1:0]  mask;
  logic [CW-1:0]       term;
  logic                t_clr, t_hit, setup_end;

  always_comb begin
    case (phase)
      PH_SETUP: term = CW'(S_EFF - 1);
      PH_HIGH:  term = CW'(P_EFF - 1);
      PH_HOLD:  term = CW'(H_EFF - 1);
      default:  term = '0;
    endcase
  end

  assign t_clr     = (phase == PH_IDLE) || t_hit;
  assign setup_end = (phase == PH_SETUP) && t_hit;

  swb_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst(rst), .clr(t_clr), .term(term), .hit(t_hit)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign mask[d]           = bc_q || (dev_q == IDX_W'(d));
    assign sh_we[d]          = setup_end && mask[d];
    assign sh_wd[d*CH +: CH] = bc_q ? bcast_bus[d*CH +: CH] : ctl_bus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      req_ready <= 1'b1;
      err_o     <= 1'b0;
      ctl_bus   <= '0;
      bcast_bus <= '0;
      latch_o   <= '0;
      bc_q      <= 1'b0;
      dev_q     <= '0;
    end else begin
      err_o <= 1'b0;
      case (phase)
        PH_IDLE: if (req_valid) begin
          if (!req_bcast && ({1'b0, req_dev} >= NDEV_L)) begin
            err_o <= 1'b1;
          end else begin
            phase     <= PH_SETUP;
            req_ready <= 1'b0;
            bc_q      <= req_bcast;
            dev_q     <= req_dev;
            if (req_bcast) bcast_bus <= req_wide;
            else           ctl_bus   <= req_pat;
          end
        end
        PH_SETUP: if (t_hit) begin
          phase   <= PH_HIGH;
          latch_o <= mask;
        end
        PH_HIGH: if (t_hit) begin
          phase   <= PH_HOLD;
          latch_o <= '0;
        end
        PH_HOLD: if (t_hit) begin
          phase     <= PH_IDLE;
          req_ready <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swbank_seq.sv
module swbank_seq #(
  parameter int NUM_DEV   = 3,
  parameter int CH        = 4,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int IDX_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_bcast,
  input  logic [IDX_W-1:0]      req_dev,
  input  logic [CH-1:0]         req_pat,
  input  logic [NUM_DEV*CH-1:0] req_wide,
  output logic                  err_o,
  output logic [CH-1:0]         ctl_bus,
  output logic [NUM_DEV*CH-1:0] bcast_bus,
  output logic [NUM_DEV-1:0]    latch_o,
  input  logic [IDX_W-1:0]      rb_dev,
  output logic [CH-1:0]         rb_state
);
  logic [NUM_DEV-1:0]    sh_we;
  logic [NUM_DEV*CH-1:0] sh_wd;

  swb_fsm #(
    .NUM_DEV(NUM_DEV), .CH(CH), .IDX_W(IDX_W),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) fsm_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_bcast(req_bcast), .req_dev(req_dev),
    .req_pat(req_pat), .req_wide(req_wide),
    .req_ready(req_ready), .err_o(err_o),
    .ctl_bus(ctl_bus), .bcast_bus(bcast_bus), .latch_o(latch_o),
    .sh_we(sh_we), .sh_wd(sh_wd)
  );

  swb_shadow #(.NUM_DEV(NUM_DEV), .CH(CH), .IDX_W(IDX_W)) shadow_i (
    .clk(clk), .rst(rst), .we(sh_we), .wd(sh_wd),
    .rb_dev(rb_dev), .rb_state(rb_state)
  );
endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
  parameter int NUM_DEV   = 3,
  parameter int CH        = 4,
  parameter int PULSE_CYC = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_ready,
  input logic                  err_o,
  input logic [CH-1:0]         ctl_bus,
  input logic [NUM_DEV*CH-1:0] bcast_bus,
  input logic [NUM_DEV-1:0]    latch_o
);
  localparam int P_EFF = (PULSE_CYC == 0) ? 1 : PULSE_CYC;

  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)                         hi_cnt <= '0;
    else if (latch_o == '0)          hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF)     hi_cnt <= hi_cnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (latch_o == '0 && req_ready && !err_o));

  assert_strobe_shape_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(latch_o) || (&latch_o));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(|latch_o) |-> (hi_cnt >= 16'(P_EFF)));

  assert_bus_held_R5: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> ($stable(ctl_bus) && $stable(bcast_bus)));

  assert_bus_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ctl_bus) || !$stable(bcast_bus)) |-> (latch_o == '0 && $past(latch_o) == '0));

  assert_reject_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (latch_o == '0 && req_ready));

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (|latch_o) |-> !req_ready);
endmodule

bind swbank_seq swb_checker #(
  .NUM_DEV(NUM_DEV), .CH(CH), .PULSE_CYC(PULSE_CYC)
) chk_i (
  .clk(clk), .rst(rst), .req_ready(req_ready), .err_o(err_o),
  .ctl_bus(ctl_bus), .bcast_bus(bcast_bus), .latch_o(latch_o)
);

// File: tb/swbank_seq_tb_top.sv
module swbank_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int C = 4;
  localparam int S = 2;
  localparam int P = 3;
  localparam int H = 2;
  localparam int IW = 2;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, req_bcast = 0;
  logic [IW-1:0] req_dev = 0, rb_dev = 0;
  logic [C-1:0] req_pat = 0;
  logic [N*C-1:0] req_wide = 0;
  logic req_ready, err_o;
  logic [C-1:0] ctl_bus, rb_state;
  logic [N*C-1:0] bcast_bus;
  logic [N-1:0] latch_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swbank_seq #(.NUM_DEV(N), .CH(C), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bcast(req_bcast), .req_dev(req_dev), .req_pat(req_pat), .req_wide(req_wide),
    .err_o(err_o), .ctl_bus(ctl_bus), .bcast_bus(bcast_bus), .latch_o(latch_o),
    .rb_dev(rb_dev), .rb_state(rb_state)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_phase = 0, m_cnt = 0, m_dev = 0;
  bit m_bc = 0, m_ready = 1, m_err = 0;
  logic [C-1:0] m_bus = 0, m_rb = 0;
  logic [N*C-1:0] m_wide = 0;
  logic [N-1:0] m_latch = 0;
  logic [C-1:0] m_sh [N];
  logic [C-1:0] exp_sh [N];

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_ready = 1; m_err = 0; m_bus = 0; m_wide = 0;
      m_latch = 0; m_rb = 0;
      for (int d = 0; d < N; d++) m_sh[d] = 0;
    end else begin
      m_err = 0;
      m_rb = (int'(rb_dev) < N) ? m_sh[rb_dev] : '0;
      case (m_phase)
        0: if (req_valid) begin
             if (!req_bcast && int'(req_dev) >= N) m_err = 1;
             else begin
               m_phase = 1; m_cnt = 0; m_ready = 0; m_bc = req_bcast; m_dev = int'(req_dev);
               if (req_bcast) m_wide = req_wide; else m_bus = req_pat;
             end
           end
        1: if (m_cnt == S-1) begin
             m_phase = 2; m_cnt = 0;
             for (int d = 0; d < N; d++)
               if (m_bc || d == m_dev) begin
                 m_latch[d] = 1;
                 m_sh[d] = m_bc ? m_wide[d*C +: C] : m_bus;
               end
           end else m_cnt++;
        2: if (m_cnt == P-1) begin m_phase = 3; m_cnt = 0; m_latch = 0; end
           else m_cnt++;
        default: if (m_cnt == H-1) begin m_phase = 0; m_cnt = 0; m_ready = 1; end
           else m_cnt++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 latch_o vs model", 32'(latch_o), 32'(m_latch));
      check("R6 ctl_bus vs model", 32'(ctl_bus), 32'(m_bus));
      check("R7 bcast_bus vs model", 32'(bcast_bus), 32'(m_wide));
      check("R10 req_ready vs model", 32'(req_ready), 32'(m_ready));
      check("R8 err_o vs model", 32'(err_o), 32'(m_err));
      check("R9 rb_state vs model", 32'(rb_state), 32'(m_rb));
    end
  end

  task automatic send(input bit bc, input int dev, input logic [C-1:0] pat,
                      input logic [N*C-1:0] wide);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_bcast = bc; req_dev = IW'(dev); req_pat = pat; req_wide = wide;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic timed_unicast(input int dev, input logic [C-1:0] pat);
    int k, j, h;
    send(0, dev, pat, '0);
    check("R2 pattern on shared bus", 32'(ctl_bus), 32'(pat));
    k = 0; while (latch_o == 0) begin @(negedge clk); k++; end
    check("R3 setup cycles", k, S);
    check("R2 only selected strobe", 32'(latch_o), 32'(1 << dev));
    j = 0; while (latch_o != 0) begin @(negedge clk); j++; end
    check("R4 pulse cycles", j, P);
    h = 0; while (!req_ready) begin
      check("R5 bus held after fall", 32'(ctl_bus), 32'(pat));
      @(negedge clk); h++;
    end
    check("R5 hold cycles", h, H);
    exp_sh[dev] = pat;
  endtask

  task automatic readback(input int dev, input logic [C-1:0] exp, input string tag);
    rb_dev = IW'(dev);
    @(negedge clk);
    check(tag, 32'(rb_state), 32'(exp));
  endtask

  initial begin
    for (int d = 0; d < N; d++) exp_sh[d] = 0;
    repeat (3) @(negedge clk);
    check("R1 strobes low in reset", 32'(latch_o), 0);
    check("R1 ready high in reset", 32'(req_ready), 1);
    rst = 0;
    @(negedge clk);
    check("R1 strobes low after reset", 32'(latch_o), 0);
    check("R1 err low after reset", 32'(err_o), 0);
    for (int d = 0; d < N; d++) readback(d, 4'h0, "R1 shadow zero after reset");

    timed_unicast(0, 4'hA);
    timed_unicast(2, 4'h5);
    timed_unicast(1, 4'hF);
    for (int d = 0; d < N; d++) readback(d, exp_sh[d], "R9 readback after unicast");
    readback(3, 4'h0, "R9 out-of-range readback is zero");

    // rejected index
    send(0, 3, 4'h7, '0);
    check("R8 err raised", 32'(err_o), 1);
    check("R8 ready stays high", 32'(req_ready), 1);
    for (int i = 0; i < 4; i++) begin
      check("R8 no strobe", 32'(latch_o), 0);
      @(negedge clk);
    end
    check("R8 err one cycle", 32'(err_o), 0);
    for (int d = 0; d < N; d++) readback(d, exp_sh[d], "R8 shadow unchanged");

    // broadcast: dev0=3, dev1=C, dev2=9
    send(1, 0, 4'h0, 12'h9C3);
    check("R7 wide bus driven", 32'(bcast_bus), 32'h9C3);
    while (latch_o == 0) @(negedge clk);
    check("R7 all strobes together", 32'(latch_o), 32'h7);
    exp_sh[0] = 4'h3; exp_sh[1] = 4'hC; exp_sh[2] = 4'h9;
    while (!req_ready) @(negedge clk);
    for (int d = 0; d < N; d++) readback(d, exp_sh[d], "R7 broadcast slice per device");

    // busy: a request held while a sequence runs has no effect
    send(0, 0, 4'h1, '0);
    req_valid = 1; req_bcast = 0; req_dev = 1; req_pat = 4'h0;
    @(negedge clk);
    check("R10 ready low while busy", 32'(req_ready), 0);
    @(negedge clk);
    req_valid = 0;
    exp_sh[0] = 4'h1;
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    readback(1, exp_sh[1], "R10 busy request ignored");
    readback(0, exp_sh[0], "R10 running write landed");

    // back-to-back patterns
    for (int i = 0; i < 6; i++) begin
      int dv;
      dv = i % N;
      timed_unicast(dv, C'(i * 3 + 2));
    end
    for (int d = 0; d < N; d++) readback(d, exp_sh[d], "R9 readback after sequence");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule